// File: doc/BRIEF.md
# Multi-Page-Size Translation Lookaside Buffer

This block is a fully associative address translation buffer with 64 entries. Each lookup request presents a 64-bit virtual address, a 13-bit context, a user-mode flag and a write flag. All entries are compared in parallel. Each entry carries its own page size, chosen from 8 KB, 64 KB, 512 KB and 4 MB. It also carries a global flag that lets the entry match under any context. When several entries match, the entry with the lowest index is used. A hit returns a 41-bit physical address aligned to 8 KB. The block raises a privilege fault when a user access lands on a supervisor-only entry, and a write fault when a store lands on an entry that is not writable.

Entries are loaded through a write port that takes an index, a tag word and a translation word. The surrounding MMU chooses which entry to replace, handles demaps and walks the page tables. The requester takes the context from the low 13 bits of its primary context register.

Field layout, which the surrounding MMU must follow:
- Tag word: bits [63:13] hold the virtual page and bits [12:0] hold the context.
- Translation word:
  - bit 63: valid
  - bits [62:61]: page size
  - bits [40:13]: physical frame
  - bit 2: supervisor-only
  - bit 1: writable
  - bit 0: global

Top module: `xlat_buffer`

## Requirements
- R1: While reset is asserted and after it is released, every entry is invalid. Outputs respValid, hit, physAddr, privFault and writeFault are all 0, and a lookup before any write misses.
- R2: The page-size field (translation bits [62:61]) decodes as 0 = 8 KB, 1 = 64 KB, 2 = 512 KB and 3 = 4 MB. The virtual address and the tag are compared only above bit 13, 16, 19 or 22 respectively, so an address one page past the base misses.
- R3: An entry with the valid bit (translation bit 63) clear never hits.
- R4: An entry hits only if its global bit (translation bit 0) is set or its tag context (tag bits [12:0]) equals lookupCtx.
- R5: On a hit, physAddr = ((T & M) | (VA & ~M)) & 0x1FFFFFFE000. Here T is the translation word and M is the entry's size mask. Translation bits above 40 and address bits below 13 never reach physAddr.
- R6: When several entries hit, the one with the lowest index supplies the result.
- R7: A hit on an entry whose supervisor-only bit (translation bit 2) is set raises privFault when lookupUser is 1 and not when it is 0. Hit and physAddr are still reported.
- R8: A hit with lookupWrite = 1 on an entry whose writable bit (translation bit 1) is clear raises writeFault. A read never raises it.
- R9: A response appears with respValid = 1 exactly one cycle after a cycle with lookupValid = 1, and respValid = 0 after an idle cycle. On a miss, hit, physAddr and both faults are 0.
- R10: A write takes effect at the clock edge. A lookup in the same cycle as a write to a matching entry sees the old contents, and the lookup in the next cycle sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupVa | input | 64 | Virtual address to translate |
| lookupCtx | input | 13 | Context of the access |
| lookupUser | input | 1 | 1 = user-mode access |
| lookupWrite | input | 1 | 1 = store access |
| wrEnable | input | 1 | Load an entry this cycle |
| wrIndex | input | 6 | Entry index to load |
| wrTag | input | 64 | Tag word (virtual page and context) |
| wrEntry | input | 64 | Translation word |
| respValid | output | 1 | Response of the previous cycle's lookup |
| hit | output | 1 | A valid matching entry was found |
| physAddr | output | 41 | Translated physical address, 0 on a miss |
| privFault | output | 1 | User access to a supervisor-only entry |
| writeFault | output | 1 | Store to a non-writable entry |

## Verification
Every lookup result is due exactly one clock after its request, and an entry write is visible to a lookup one clock after it is presented. The driver applies each request on a falling edge and places the expected hit, address and fault values in a queue at that moment. The monitor takes the front item off the queue on every falling edge that shows respValid, so each comparison lands on the first edge after the registering clock. The same-cycle write case relies on the same one-cycle offset: it expects the old result for the overlapping lookup and the new result for the lookup one cycle later.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int NUM_ENTRIES = 64;
  localparam int IDX_W       = $clog2(NUM_ENTRIES);
  localparam int VA_W        = 64;
  localparam int CTX_W       = 13;
  localparam int PA_W        = 41;
  localparam int PAGE_BASE   = 13;
  localparam int PAGE_STEP   = 3;

  localparam int TTE_VALID   = 63;
  localparam int TTE_SZ_HI   = 62;
  localparam int TTE_SZ_LO   = 61;
  localparam int TTE_PRIV    = 2;
  localparam int TTE_WRITE   = 1;
  localparam int TTE_GLOBAL  = 0;

  localparam logic [PA_W-1:0] PA_KEEP =
    {{(PA_W-PAGE_BASE){1'b1}}, {PAGE_BASE{1'b0}}};

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
  } xlat_strobe_t;

  typedef struct packed {
    logic            any;
    logic            priv;
    logic            writable;
    logic [PA_W-1:0] pa;
  } xlat_match_t;

  function automatic logic [VA_W-1:0] pageMask(input logic [1:0] sz);
    logic [VA_W-1:0] ones;
    ones = '1;
    return ones << (PAGE_BASE + PAGE_STEP * int'(sz));
  endfunction
endpackage

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  xlat_strobe_t      stb,
  input  logic [VA_W-1:0]   wrTag,
  input  logic [VA_W-1:0]   wrTte,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [CTX_W-1:0]  lkCtx,
  output xlat_match_t       match
);
  logic [VA_W-1:0] tagMem [NUM_ENTRIES];
  logic [VA_W-1:0] tteMem [NUM_ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tagMem[i] <= '0;
        tteMem[i] <= '0;
      end
    end else if (stb.wrEn) begin
      tagMem[stb.wrIdx] <= wrTag;
      tteMem[stb.wrIdx] <= wrTte;
    end
  end

  logic [NUM_ENTRIES-1:0] hitVec;
  logic [NUM_ENTRIES-1:0] firstVec;
  logic [NUM_ENTRIES-1:0] privVec;
  logic [NUM_ENTRIES-1:0] wrOkVec;
  logic [PA_W-1:0]        paVec [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic [VA_W-1:0] mask;
    logic            ctxOk;
    logic [PA_W-1:0] joined;
    logic            unusedHigh;

    assign mask   = pageMask(tteMem[e][TTE_SZ_HI:TTE_SZ_LO]);
    assign ctxOk  = tteMem[e][TTE_GLOBAL] || (tagMem[e][CTX_W-1:0] == lkCtx);
    assign hitVec[e] = tteMem[e][TTE_VALID] && ctxOk &&
                       ((tagMem[e] & mask) == (lkVa & mask));
    assign joined = (tteMem[e][PA_W-1:0] & mask[PA_W-1:0]) |
                    (lkVa[PA_W-1:0] & ~mask[PA_W-1:0]);
    assign paVec[e]   = joined & PA_KEEP;
    assign privVec[e] = tteMem[e][TTE_PRIV];
    assign wrOkVec[e] = tteMem[e][TTE_WRITE];
    assign unusedHigh = ^tteMem[e][TTE_SZ_LO-1:PA_W];
  end

  assign firstVec = hitVec & (~hitVec + 1'b1);

  always_comb begin
    match = '0;
    match.any = |hitVec;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (firstVec[e]) begin
        match.pa       = match.pa | paVec[e];
        match.priv     = match.priv | privVec[e];
        match.writable = match.writable | wrOkVec[e];
      end
    end
  end

  // R6: at most one entry is chosen, and one is chosen whenever any hits
  a_r6_single_pick: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(firstVec) && ((hitVec == '0) || ($countones(firstVec) == 1)));

  // R6: the chosen entry is itself a hitting entry
  a_r6_pick_is_hit: assert property (@(posedge clk) disable iff (!rstN)
    (firstVec & ~hitVec) == '0);

  // R5: translated address is always page aligned
  a_r5_pa_aligned: assert property (@(posedge clk) disable iff (!rstN)
    match.pa[PAGE_BASE-1:0] == '0);
endmodule

// File: rtl/xlat_control.sv
module xlat_control
  import xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             lookupUser,
  input  logic             lookupWrite,
  input  logic             wrEnable,
  input  logic [IDX_W-1:0] wrIndex,
  input  xlat_match_t      match,
  output xlat_strobe_t     stb,
  output logic             respValid,
  output logic             hit,
  output logic [PA_W-1:0]  physAddr,
  output logic             privFault,
  output logic             writeFault
);
  assign stb.wrEn  = wrEnable;
  assign stb.wrIdx = wrIndex;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      hit        <= 1'b0;
      physAddr   <= '0;
      privFault  <= 1'b0;
      writeFault <= 1'b0;
    end else begin
      respValid  <= lookupValid;
      hit        <= lookupValid && match.any;
      physAddr   <= (lookupValid && match.any) ? match.pa : '0;
      privFault  <= lookupValid && match.any && match.priv && lookupUser;
      writeFault <= lookupValid && match.any && !match.writable && lookupWrite;
    end
  end

  // R9: a request is answered on the next cycle
  a_r9_resp_next: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  // R9: no response follows an idle cycle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  // R9: a miss carries no address and no fault
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (physAddr == '0) && !privFault && !writeFault);

  // R7: a privilege fault only follows a user access
  a_r7_user_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(privFault) |-> $past(lookupUser) && hit);

  // R8: a write fault only follows a store
  a_r8_store_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeFault) |-> $past(lookupWrite) && hit);
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VA_W-1:0]  lookupVa,
  input  logic [CTX_W-1:0] lookupCtx,
  input  logic             lookupUser,
  input  logic             lookupWrite,
  input  logic             wrEnable,
  input  logic [IDX_W-1:0] wrIndex,
  input  logic [VA_W-1:0]  wrTag,
  input  logic [VA_W-1:0]  wrEntry,
  output logic             respValid,
  output logic             hit,
  output logic [PA_W-1:0]  physAddr,
  output logic             privFault,
  output logic             writeFault
);
  xlat_strobe_t stb;
  xlat_match_t  match;

  xlat_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .lookupValid(lookupValid),
    .lookupUser (lookupUser),
    .lookupWrite(lookupWrite),
    .wrEnable   (wrEnable),
    .wrIndex    (wrIndex),
    .match      (match),
    .stb        (stb),
    .respValid  (respValid),
    .hit        (hit),
    .physAddr   (physAddr),
    .privFault  (privFault),
    .writeFault (writeFault)
  );

  xlat_datapath u_datapath (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .wrTag(wrTag),
    .wrTte(wrEntry),
    .lkVa (lookupVa),
    .lkCtx(lookupCtx),
    .match(match)
  );
endmodule

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;
  localparam int ClkPeriod = 10;

  localparam logic [63:0] V  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PR = 64'h4;
  localparam logic [63:0] WR = 64'h2;
  localparam logic [63:0] GL = 64'h1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [63:0] lookupVa = '0;
  logic [12:0] lookupCtx = '0;
  logic        lookupUser = 1'b0;
  logic        lookupWrite = 1'b0;
  logic        wrEnable = 1'b0;
  logic [5:0]  wrIndex = '0;
  logic [63:0] wrTag = '0;
  logic [63:0] wrEntry = '0;
  logic        respValid, hit, privFault, writeFault;
  logic [40:0] physAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        hit;
    logic [40:0] pa;
    logic        pf;
    logic        wf;
    string       req;
  } exp_t;
  exp_t q[$];

  always #(ClkPeriod/2) clk = ~clk;

  xlat_buffer u_xlat_buffer (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVa(lookupVa),
    .lookupCtx(lookupCtx), .lookupUser(lookupUser), .lookupWrite(lookupWrite),
    .wrEnable(wrEnable), .wrIndex(wrIndex), .wrTag(wrTag), .wrEntry(wrEntry),
    .respValid(respValid), .hit(hit), .physAddr(physAddr),
    .privFault(privFault), .writeFault(writeFault)
  );

  function automatic logic [63:0] sz(input int s);
    return 64'(s) << 61;
  endfunction

  // Address formula stated in R5
  function automatic logic [40:0] calcPa(input logic [63:0] tte, input logic [63:0] va);
    logic [63:0] m;
    logic [63:0] r;
    m = 64'hFFFF_FFFF_FFFF_FFFF << (13 + 3 * int'(tte[62:61]));
    r = ((tte & m) | (va & ~m)) & 64'h1FF_FFFF_E000;
    return r[40:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (q.size() == 0) begin
        check(1'b0, "R9", "unexpected response", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(hit == e.hit && physAddr == e.pa && privFault == e.pf &&
              writeFault == e.wf, e.req, "hit/pa/pf/wf",
              {hit, privFault, writeFault, 20'd0, physAddr},
              {e.hit, e.pf, e.wf, 20'd0, e.pa});
      end
    end
  end

  task automatic lookup(input logic [63:0] va, input logic [12:0] ctx,
                        input logic user, input logic wr, input logic eh,
                        input logic [40:0] epa, input logic epf,
                        input logic ewf, input string req);
    exp_t e;
    @(negedge clk);
    lookupValid = 1'b1;
    lookupVa    = va;
    lookupCtx   = ctx;
    lookupUser  = user;
    lookupWrite = wr;
    e.hit = eh; e.pa = epa; e.pf = epf; e.wf = ewf; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic writeEntry(input int idx, input logic [63:0] tag, input logic [63:0] tte);
    @(negedge clk);
    lookupValid = 1'b0;
    wrEnable = 1'b1;
    wrIndex  = 6'(idx);
    wrTag    = tag;
    wrEntry  = tte;
    @(negedge clk);
    wrEnable = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] t5, t6, t10, t11, t20, t21, t30, t31, t40;
    t5  = V | sz(0) | WR | 64'h0000_00AB_CDE0_2000;
    t6  = V | sz(3) | GL | 64'h0000_0001_8012_4000;
    t10 = V | sz(1) | 64'h0000_0000_0055_0000;
    t11 = V | sz(2) | 64'h0000_2000_0000_0000 | 64'h0000_01FF_FF80_0000;
    t20 = V | sz(0) | 64'h0000_0011_1110_0000;
    t21 = V | sz(0) | 64'h0000_0022_2220_0000;
    t30 = V | sz(0) | PR | WR | 64'h0000_0000_0444_0000;
    t31 = V | sz(0) | 64'h0000_0000_0666_0000;
    t40 = V | sz(0) | WR | 64'h0000_0000_0777_0000;

    // R1: outputs during and after reset
    repeat (3) @(negedge clk);
    check({respValid, hit, privFault, writeFault} == 4'b0 && physAddr == '0,
          "R1", "outputs in reset", {respValid, hit, privFault, writeFault}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check({respValid, hit, privFault, writeFault} == 4'b0 && physAddr == '0,
          "R1", "outputs after reset", {respValid, hit, privFault, writeFault}, 64'd0);
    lookup(64'h0, 13'h0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R1");
    idle();

    // R2 R4 R5: 8 KB entry, context compare
    writeEntry(5, 64'h0000_1234_5678_A042, t5);
    lookup(64'h0000_1234_5678_A123, 13'h042, 1'b0, 1'b0, 1'b1, 41'h0AB_CDE0_2000, 1'b0, 1'b0, "R5");
    lookup(64'h0000_1234_5678_A123, 13'h043, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R4");
    lookup(64'h0000_1234_5678_C000, 13'h042, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2");
    lookup(64'h0000_1234_5678_A123, 13'h042, 1'b1, 1'b1, 1'b1, 41'h0AB_CDE0_2000, 1'b0, 1'b0, "R8");
    idle();

    // R4 R2: 4 MB global entry
    writeEntry(6, 64'h0000_00F0_0000_0007, t6);
    lookup(64'h0000_00F0_003F_E123, 13'h099, 1'b0, 1'b0, 1'b1, 41'h1_803F_E000, 1'b0, 1'b0, "R4");
    lookup(64'h0000_00F0_0040_0000, 13'h007, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2");
    idle();

    // R2 R5: 64 KB and 512 KB entries
    writeEntry(10, 64'h0000_0000_7770_0001, t10);
    writeEntry(11, 64'h0000_0000_3308_0001, t11);
    lookup(64'h0000_0000_7770_FFFF, 13'h001, 1'b0, 1'b0, 1'b1, calcPa(t10, 64'h7770_FFFF), 1'b0, 1'b0, "R2");
    lookup(64'h0000_0000_7771_0000, 13'h001, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2");
    lookup(64'h0000_0000_330F_ABCD, 13'h001, 1'b0, 1'b0, 1'b1, 41'h1FF_FF87_A000, 1'b0, 1'b0, "R5");
    lookup(64'h0000_0000_3310_0000, 13'h001, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2");
    idle();

    // R6 R3: overlapping entries, then the lower one invalidated
    writeEntry(21, 64'h0000_0ABC_0000_0003, t21);
    writeEntry(20, 64'h0000_0ABC_0000_0003, t20);
    lookup(64'h0000_0ABC_0000_0010, 13'h003, 1'b0, 1'b0, 1'b1, 41'h011_1110_0000, 1'b0, 1'b0, "R6");
    idle();
    writeEntry(20, 64'h0000_0ABC_0000_0003, t20 & ~V);
    lookup(64'h0000_0ABC_0000_0010, 13'h003, 1'b0, 1'b0, 1'b1, 41'h022_2220_0000, 1'b0, 1'b0, "R3");
    idle();

    // R7: supervisor-only entry
    writeEntry(30, 64'h0000_0000_0BAD_0005, t30);
    lookup(64'h0000_0000_0BAD_0100, 13'h005, 1'b1, 1'b0, 1'b1, 41'h0444_0000, 1'b1, 1'b0, "R7");
    lookup(64'h0000_0000_0BAD_0100, 13'h005, 1'b0, 1'b0, 1'b1, 41'h0444_0000, 1'b0, 1'b0, "R7");
    lookup(64'h0000_0000_0BAD_0100, 13'h005, 1'b1, 1'b1, 1'b1, 41'h0444_0000, 1'b1, 1'b0, "R7");
    idle();

    // R8: non-writable entry
    writeEntry(31, 64'h0000_0000_0CAF_E005, t31);
    lookup(64'h0000_0000_0CAF_E008, 13'h005, 1'b0, 1'b1, 1'b1, 41'h0666_0000, 1'b0, 1'b1, "R8");
    lookup(64'h0000_0000_0CAF_E008, 13'h005, 1'b0, 1'b0, 1'b1, 41'h0666_0000, 1'b0, 1'b0, "R8");
    lookup(64'h0000_0000_0CAF_E008, 13'h005, 1'b1, 1'b1, 1'b1, 41'h0666_0000, 1'b0, 1'b1, "R8");
    idle();

    // R10: write and lookup in the same cycle, then the next cycle
    @(negedge clk);
    wrEnable = 1'b1; wrIndex = 6'd40;
    wrTag = 64'h0000_0000_0DDD_0005; wrEntry = t40;
    lookupValid = 1'b1; lookupVa = 64'h0000_0000_0DDD_0000;
    lookupCtx = 13'h005; lookupUser = 1'b0; lookupWrite = 1'b0;
    begin
      exp_t e;
      e.hit = 1'b0; e.pa = '0; e.pf = 1'b0; e.wf = 1'b0; e.req = "R10";
      q.push_back(e);
    end
    @(negedge clk);
    wrEnable = 1'b0;
    begin
      exp_t e;
      e.hit = 1'b1; e.pa = 41'h0777_0000; e.pf = 1'b0; e.wf = 1'b0; e.req = "R10";
      q.push_back(e);
    end
    idle();

    // R9: quiet after idle, queue drained
    @(negedge clk);
    check(respValid == 1'b0, "R9", "respValid after idle", 64'(respValid), 64'd0);
    check(q.size() == 0, "R9", "pending responses", 64'(q.size()), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule